// File: doc/BRIEF.md
# Light-Sensor Register Slave on a Two-Wire Serial Bus

This block is the serial-bus target of a light-sensor controller. It watches the clock and data lines of an I2C bus, synchronizes them into the system clock domain, and recognizes START, repeated START and STOP. It answers only to the 7-bit identifier 7'b1000100. It drives the data line only through an open-drain pull-down enable. A write transaction sets the register pointer and may then store one or more bytes. A read sets the pointer in a write phase and then, after a repeated START, returns bytes for as long as the master acknowledges them.

Behind the bus logic sits a 16-entry register map. It holds two configuration bytes, a 16-bit low threshold and a 16-bit high threshold, and an identity byte that carries a sticky brownout flag. Two read-only bytes present the latest conversion result from the measurement logic. When register 0x00 has been read completely, the block sends a one-cycle pulse so that the interrupt logic can drop its pending status.

Top module: `lux_i2c_regs`

## Requirements
- R1: An address byte whose upper seven bits equal 7'b1000100 is acknowledged by pulling SDA low on the ninth clock. Bit 0 of that byte selects read (1) or write (0). Bytes are transferred MSB first.
- R2: An address byte with any other identifier is not acknowledged, and SDA stays released for the rest of the transaction until the next START.
- R3: In a write, the byte after the address byte is the register pointer. The next byte is stored at that address. Each byte is acknowledged, and the stored value reads back and appears on the configuration and threshold outputs (low threshold: 0x05 high byte, 0x04 low byte; high threshold: 0x07 high byte, 0x06 low byte).
- R4: In a burst write, each further data byte goes to the next address. After address 0x0F the pointer wraps to 0x00.
- R5: A read consists of a pointer write, a repeated START and the read address byte. The slave sends the next byte after every master ACK, stops after a master NACK, and releases SDA.
- R6: In a burst read the pointer advances after each byte and wraps from 0x0F to 0x00. A later read with no pointer byte continues at the advanced pointer.
- R7: After a write, the pointer stays at the last address written, so a read with no pointer byte returns that register.
- R8: A STOP that arrives before a data byte and its ACK clock have completed leaves every register unchanged.
- R9: After reset, addresses 0x00, 0x01, 0x04 and 0x05 read 0x00, addresses 0x06 and 0x07 read 0xFF, and 0x0F reads 0xA8.
- R10: Address 0x02 returns result_i[7:0] and 0x03 returns result_i[15:8], and writes to them are ignored. Addresses 0x08 to 0x0E and above 0x0F read 0x00 and ignore writes.
- R11: Bit 7 of 0x0F is a brownout flag. It is 1 after reset and holds until the host writes it. Bits 5:3 of 0x0F always read 3'b101, and the other bits read 0.
- R12: Bit 2 of 0x00 reads int_status_i and cannot be written. When the last bit of a read of 0x00 has been sent, int_clear_o pulses high for exactly one cycle. Reads of other addresses do not pulse it.
- R13: START and STOP are SDA falling and rising edges while SCL is high. After a STOP, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| result_i | input | 16 | Latest conversion result |
| int_status_i | input | 1 | Pending interrupt status, shown at bit 2 of 0x00 |
| cfg0_o | output | 8 | Stored configuration byte 0 (bit 2 always 0) |
| cfg1_o | output | 8 | Stored configuration byte 1 |
| low_thr_o | output | 16 | Lower interrupt threshold |
| high_thr_o | output | 16 | Upper interrupt threshold |
| brownout_o | output | 1 | Sticky brownout flag |
| int_clear_o | output | 1 | One-cycle pulse after register 0x00 is read |

## Verification
Some properties are checked on every cycle: the clear pulse never lasts longer than one cycle, SDA is released in the cycle after a STOP, register writes happen only on an SCL falling edge, and the thresholds and brownout flag change only when a matching write strobe is present. Other behaviours can be shown only by the bench's transactions. These are identifier matching, pointer wrap in both directions, where the pointer rests after writes and reads, the aborted transfer, the read-only and unmapped addresses, and the exact data returned in burst reads.

// File: rtl/lux_i2c_pkg.sv
`timescale 1ns/1ps
package lux_i2c_pkg;
    localparam int BYTE_W    = 8;
    localparam int RES_W     = 2 * BYTE_W;
    localparam int THR_BYTES = 4;
    localparam logic [6:0] DEV_ID = 7'b1000100;
    localparam logic [7:0] MAP_LAST = 8'h0F;
    localparam logic [7:0] A_CFG0  = 8'h00;
    localparam logic [7:0] A_CFG1  = 8'h01;
    localparam logic [7:0] A_RESL  = 8'h02;
    localparam logic [7:0] A_RESH  = 8'h03;
    localparam logic [7:0] A_THR0  = 8'h04;
    localparam logic [7:0] A_IDENT = 8'h0F;
    localparam logic [2:0] ID_CODE = 3'b101;
    localparam logic [7:0] STAT_MASK = 8'h04;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEVADDR, ST_DEVACK, ST_REGADDR, ST_REGACK,
        ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    function automatic logic [BYTE_W-1:0] ptr_next(input logic [BYTE_W-1:0] p);
        return (p >= MAP_LAST) ? '0 : p + 8'd1;
    endfunction

    function automatic logic [BYTE_W-1:0] thr_reset(input int idx);
        return (idx >= THR_BYTES / 2) ? 8'hFF : 8'h00;
    endfunction
endpackage

// File: rtl/lux_bus_sync.sv
`timescale 1ns/1ps
module lux_bus_sync
    import lux_i2c_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [SYNC_DEPTH-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q, scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_DEPTH-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_DEPTH-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_ff[SYNC_DEPTH-1];
    assign sda_s = sda_ff[SYNC_DEPTH-1];

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/lux_byte_engine.sv
`timescale 1ns/1ps
module lux_byte_engine
    import lux_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_addr,
    output reg_wr_t           wr,
    output logic              sda_oe,
    output logic              int_clear
);
    bus_state_e        st;
    logic [BYTE_W-1:0] shreg, ptr, wr_target;
    logic [3:0]        cnt;
    logic              adv, rnw, mack;

    assign wr_target = adv ? ptr_next(ptr) : ptr;
    assign rd_addr   = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; shreg <= '0; ptr <= '0; cnt <= '0;
            adv <= 1'b0; rnw <= 1'b0; mack <= 1'b0;
            sda_oe <= 1'b0; int_clear <= 1'b0; wr <= '0;
        end else begin
            int_clear <= 1'b0;
            wr.en     <= 1'b0;
            if (evt.stop) begin
                st <= ST_IDLE; sda_oe <= 1'b0;
            end else if (evt.start) begin
                st <= ST_DEVADDR; cnt <= '0; sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
                        if (evt.scl_rise && cnt < 4'd8) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (st == ST_DEVADDR) begin
                                if (shreg[7:1] == DEV_ID) begin
                                    st <= ST_DEVACK; sda_oe <= 1'b1; rnw <= shreg[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_REGADDR) begin
                                ptr <= shreg; adv <= 1'b0;
                                st <= ST_REGACK; sda_oe <= 1'b1;
                            end else begin
                                st <= ST_WACK; sda_oe <= 1'b1;
                            end
                        end
                    end
                    ST_DEVACK: if (evt.scl_fall) begin
                        if (rnw) begin
                            shreg <= rd_data; sda_oe <= ~rd_data[7];
                            cnt <= 4'd1; st <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0; st <= ST_REGADDR;
                        end
                    end
                    ST_REGACK: if (evt.scl_fall) begin
                        sda_oe <= 1'b0; st <= ST_WDATA;
                    end
                    ST_WACK: if (evt.scl_fall) begin
                        sda_oe <= 1'b0;
                        wr <= '{en: 1'b1, addr: wr_target, data: shreg};
                        ptr <= wr_target; adv <= 1'b1;
                        st <= ST_WDATA;
                    end
                    ST_RDATA: if (evt.scl_fall) begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0; st <= ST_RACK;
                            int_clear <= (ptr == A_CFG0);
                            ptr <= ptr_next(ptr);
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (mack) begin
                                shreg <= rd_data; sda_oe <= ~rd_data[7];
                                cnt <= 4'd1; st <= ST_RDATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        int_clear |=> !int_clear);
    // R13
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !sda_oe);
    // R8
    write_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> $past(evt.scl_fall));
endmodule

// File: rtl/lux_reg_bank.sv
`timescale 1ns/1ps
module lux_reg_bank
    import lux_i2c_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  reg_wr_t                     wr,
    input  logic [BYTE_W-1:0]           rd_addr,
    input  logic [RES_W-1:0]            result_i,
    input  logic                        int_status_i,
    output logic [BYTE_W-1:0]           rd_data,
    output logic [BYTE_W-1:0]           cfg0,
    output logic [BYTE_W-1:0]           cfg1,
    output logic [THR_BYTES*BYTE_W-1:0] thr_bytes,
    output logic                        brownout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg0 <= '0; cfg1 <= '0; brownout <= 1'b1;
        end else if (wr.en) begin
            if (wr.addr == A_CFG0)  cfg0 <= wr.data & ~STAT_MASK;
            if (wr.addr == A_CFG1)  cfg1 <= wr.data;
            if (wr.addr == A_IDENT) brownout <= wr.data[7];
        end
    end

    for (genvar g = 0; g < THR_BYTES; g++) begin : g_thr
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= thr_reset(g);
            else if (wr.en && wr.addr == A_THR0 + 8'(g))
                q <= wr.data;
        end
        assign thr_bytes[g*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CFG0)
            rd_data = (cfg0 & ~STAT_MASK) | (int_status_i ? STAT_MASK : 8'h00);
        else if (rd_addr == A_CFG1)
            rd_data = cfg1;
        else if (rd_addr == A_RESL)
            rd_data = result_i[BYTE_W-1:0];
        else if (rd_addr == A_RESH)
            rd_data = result_i[RES_W-1:BYTE_W];
        else if (rd_addr >= A_THR0 && rd_addr < A_THR0 + 8'(THR_BYTES))
            rd_data = thr_bytes[rd_addr[1:0]*BYTE_W +: BYTE_W];
        else if (rd_addr == A_IDENT)
            rd_data = {brownout, 1'b0, ID_CODE, 3'b000};
    end

    // R11
    brownout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr.en && wr.addr == A_IDENT) |=> $stable(brownout));
    // R3
    thr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(thr_bytes));
endmodule

// File: rtl/lux_i2c_regs.sv
`timescale 1ns/1ps
module lux_i2c_regs
    import lux_i2c_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [15:0] result_i,
    input  logic        int_status_i,
    output logic [7:0]  cfg0_o,
    output logic [7:0]  cfg1_o,
    output logic [15:0] low_thr_o,
    output logic [15:0] high_thr_o,
    output logic        brownout_o,
    output logic        int_clear_o
);
    bus_evt_t                    evt;
    reg_wr_t                     wr;
    logic [BYTE_W-1:0]           rd_addr, rd_data;
    logic [THR_BYTES*BYTE_W-1:0] thr_bytes;

    lux_bus_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
    );

    lux_byte_engine u_engine (
        .clk(clk), .rst(rst), .evt(evt), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr(wr), .sda_oe(sda_oe_o), .int_clear(int_clear_o)
    );

    lux_reg_bank u_bank (
        .clk(clk), .rst(rst), .wr(wr), .rd_addr(rd_addr), .result_i(result_i),
        .int_status_i(int_status_i), .rd_data(rd_data), .cfg0(cfg0_o),
        .cfg1(cfg1_o), .thr_bytes(thr_bytes), .brownout(brownout_o)
    );

    assign low_thr_o  = thr_bytes[2*BYTE_W-1:0];
    assign high_thr_o = thr_bytes[4*BYTE_W-1:2*BYTE_W];
endmodule

// File: tb/lux_i2c_regs_test.sv
`timescale 1ns/1ps
module lux_i2c_regs_test;
    localparam int Q  = 6;
    localparam int WD = 190000;
    localparam logic [7:0] AW = 8'h88;
    localparam logic [7:0] AR = 8'h89;
    localparam logic [23:0] VEC [10] = '{
        24'h015A5A, 24'h041212, 24'h053434, 24'h06C3C3, 24'h073C3C,
        24'h0277EF, 24'h0311BE, 24'h095500, 24'h00FFFB, 24'h0F0028
    };

    logic clk = 0, rst = 1, scl_m = 1, sda_m = 1;
    logic [15:0] result = 16'hBEEF;
    logic int_status = 0;
    logic sda_oe, int_clear, brownout;
    logic [7:0] cfg0, cfg1;
    logic [15:0] low_thr, high_thr;
    wire sda_bus = sda_m & ~sda_oe;
    int n_chk = 0, n_err = 0, clr_cnt = 0, oe_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) begin
        if (int_clear) clr_cnt++;
        if (sda_oe) oe_cnt++;
    end

    lux_i2c_regs uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .result_i(result), .int_status_i(int_status), .cfg0_o(cfg0), .cfg1_o(cfg1),
        .low_thr_o(low_thr), .high_thr_o(high_thr), .brownout_o(brownout),
        .int_clear_o(int_clear)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); sda_m = 1; hold(); scl_m = 1; hold(); sda_m = 0; hold(); scl_m = 0; hold(); endtask
    task automatic bus_stop(); sda_m = 0; hold(); scl_m = 1; hold(); sda_m = 1; hold(); endtask
    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; hold(); scl_m = 1; hold(); s = sda_bus; hold(); scl_m = 0; hold();
    endtask
    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask
    task automatic get_byte(output logic [7:0] d, input logic mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
        clk_bit(~mack, s);
    endtask
    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        logic k;
        bus_start(); put_byte(AW, k); put_byte(a, k); put_byte(d, k); bus_stop();
    endtask
    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        logic k;
        bus_start(); put_byte(AW, k); put_byte(a, k);
        bus_start(); put_byte(AR, k); get_byte(d, 1'b0); bus_stop();
    endtask

    initial begin : watchdog
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic k1, k2, k3;
        int c0, o0;
        repeat (10) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
        // R9 R13 reset state at the ports
        check("R13 sda released at reset", sda_oe, 0);
        check("R9 cfg0 reset", cfg0, 8'h00);
        check("R9 cfg1 reset", cfg1, 8'h00);
        check("R9 low threshold reset", low_thr, 16'h0000);
        check("R9 high threshold reset", high_thr, 16'hFFFF);
        check("R11 brownout set after reset", brownout, 1);
        reg_read(8'h00, d); check("R9 read 0x00", d, 8'h00);
        reg_read(8'h05, d); check("R9 read 0x05", d, 8'h00);
        reg_read(8'h06, d); check("R9 read 0x06", d, 8'hFF);
        reg_read(8'h07, d); check("R9 read 0x07", d, 8'hFF);
        reg_read(8'h0F, d); check("R11 read 0x0F reset", d, 8'hA8);

        // R3 R10 R11 R12 table of write then readback
        for (int i = 0; i < 10; i++) begin
            reg_write(VEC[i][23:16], VEC[i][15:8]);
            reg_read(VEC[i][23:16], d);
            check($sformatf("R3 table row %0d addr %h", i, VEC[i][23:16]), d, VEC[i][7:0]);
        end
        check("R3 low threshold port", low_thr, 16'h3412);
        check("R3 high threshold port", high_thr, 16'h3CC3);
        check("R3 cfg1 port", cfg1, 8'h5A);
        check("R12 status bit not stored", cfg0, 8'hFB);
        check("R11 brownout cleared by write", brownout, 0);

        // R1 matching identifier is acknowledged
        bus_start(); put_byte(AW, k1); bus_stop();
        check("R1 address ack", k1, 1);

        // R2 foreign identifier: NACK, no drive, no write
        o0 = oe_cnt;
        bus_start(); put_byte(8'h8A, k1); put_byte(8'h01, k2); put_byte(8'h99, k3); bus_stop();
        check("R2 address nack", k1, 0);
        check("R2 no ack afterwards", k2 | k3, 0);
        check("R2 sda never driven", oe_cnt - o0, 0);
        check("R2 cfg1 untouched", cfg1, 8'h5A);

        // R4 burst write across the wrap point
        bus_start(); put_byte(AW, k1); put_byte(8'h0E, k1);
        put_byte(8'h44, k1); put_byte(8'h80, k2); put_byte(8'h61, k3); bus_stop();
        check("R4 data bytes acked", {k1, k2, k3}, 3'b111);
        check("R4 wrote 0x0F", brownout, 1);
        check("R4 wrapped to 0x00", cfg0, 8'h61);

        // R7 read with no pointer byte returns last written register; R12 clear pulse
        c0 = clr_cnt;
        bus_start(); put_byte(AR, k1); get_byte(d, 1'b0); bus_stop();
        check("R7 pointer at last written", d, 8'h61);
        check("R12 one clear pulse for 0x00", clr_cnt - c0, 1);

        // R5 R6 burst read with wrap; R12 status bit visible
        int_status = 1;
        c0 = clr_cnt;
        bus_start(); put_byte(AW, k1); put_byte(8'h0E, k1);
        bus_start(); put_byte(AR, k1);
        get_byte(d, 1'b1); check("R6 burst byte 0x0E", d, 8'h00);
        get_byte(d, 1'b1); check("R5 burst byte 0x0F", d, 8'hA8);
        get_byte(d, 1'b0); check("R6 wrapped byte 0x00", d, 8'h65);
        check("R5 sda released after master nack", sda_oe, 0);
        bus_stop();
        check("R12 clear pulse in burst", clr_cnt - c0, 1);
        bus_start(); put_byte(AR, k1); get_byte(d, 1'b0); bus_stop();
        check("R6 pointer continues at 0x01", d, 8'h5A);

        // R8 STOP in the middle of a data byte
        bus_start(); put_byte(AW, k1); put_byte(8'h01, k1);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, k2);
        bus_stop();
        check("R8 aborted write", cfg1, 8'h5A);
        check("R13 sda released after stop", sda_oe, 0);

        // R12 reading another register gives no pulse; R10 unmapped read
        c0 = clr_cnt;
        reg_read(8'h01, d);
        check("R12 no pulse for 0x01", clr_cnt - c0, 0);
        reg_read(8'h20, d);
        check("R10 unmapped reads zero", d, 8'h00);
        result = 16'h1234;
        reg_read(8'h03, d);
        check("R10 result high byte follows input", d, 8'h12);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule